// File: doc/BRIEF.md
# SRAM Low-Voltage Retention Sequencer

This block manages a static RAM through the loss and return of its supply. While the supply is healthy it lets the access controller use the RAM. If a power-fail indication appears, or the power-good indication is withdrawn, it closes the RAM to new requests at once. If an access is still in flight, it waits for the controller to report idle. It then forces the active-high chip enable low, so the RAM is deselected and keeps its contents at reduced supply.

When power is healthy again the deselect stays in force for a timed hold. The hold is counted in clock cycles derived from the clock rate and the required interval, 5 ms by default. Only after the full hold does the block reopen access. A fresh failure during the hold sends the block back to retention, and the next recovery counts the whole interval again. The block leaves reset in the recovery hold, so the same wait also covers power-up.

Top module: `sram_retention_seq`

## Requirements
- R1: During reset and directly after it, memReady is 0 and ceDeselect is 1.
- R2: With supply healthy (powerGood=1, powerFail=0) from reset release, memReady rises and ceDeselect falls at the N-th rising clock edge after release, where N = CLK_KHZ*HOLD_US/1000. Neither output changes before that edge.
- R3: In the open state, a failure sampled at an edge while ctrlBusy=0 sets memReady=0 and ceDeselect=1 from that edge.
- R4: In the open state, a failure sampled while ctrlBusy=1 sets memReady=0 from that edge. ceDeselect stays 0 for as long as ctrlBusy stays 1.
- R5: In retention, ceDeselect stays 1 and memReady stays 0 for every cycle in which the supply is not healthy.
- R6: After retention, the first edge that samples a healthy supply starts the hold. memReady rises N edges after that edge, with the supply healthy throughout.
- R7: A failure sampled during the hold returns the block to retention. The next recovery needs the full N edges again.
- R8: powerGood=0 alone counts as a failure, even with powerFail=0.
- R9: The edge that samples ctrlBusy=0 while the block is draining sets ceDeselect=1, even if the supply is already healthy again. A full hold follows before memReady rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerFail | input | 1 | Supply is about to drop |
| powerGood | input | 1 | Supply is within the normal operating range |
| ctrlBusy | input | 1 | The access controller has an access in progress |
| ceDeselect | output | 1 | 1 = hold the RAM's active-high chip enable low |
| memReady | output | 1 | 1 = the controller may accept new requests |

## Verification
A wrong state shows within one cycle as a wrong pair of memReady and ceDeselect values. Open, draining and deselected each drive a distinct pair of outputs. A hold counter that is off by one, or that fails to restart, shows as a memReady edge that arrives a cycle early, a cycle late or never. The bench keeps a cycle model next to the design and compares both outputs at every cycle. Any divergence is therefore reported at the first cycle in which it becomes visible.

// File: rtl/sram_retention_pkg.sv
package sram_retention_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_RETAIN  = 2'd2,
    ST_RECOVER = 2'd3
  } seqState_t;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } holdStrobe_t;
endpackage

// File: rtl/sram_retention_hold.sv
module sram_retention_hold
  import sram_retention_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 500000
) (
  input  logic        clk,
  input  logic        rstN,
  input  holdStrobe_t strobe,
  output logic        holdDone
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.cntClear) begin
      holdCnt <= '0;
    end else if (strobe.cntInc) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign holdDone = (holdCnt == LAST);

  // R6: the hold count never runs past its final value
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= LAST);
  // R7: a clear strobe always restarts the count
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClear |=> holdCnt == '0);
endmodule

// File: rtl/sram_retention_ctrl.sv
module sram_retention_ctrl
  import sram_retention_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        powerFail,
  input  logic        powerGood,
  input  logic        ctrlBusy,
  input  logic        holdDone,
  output holdStrobe_t strobe,
  output logic        ceDeselect,
  output logic        memReady
);
  seqState_t state, nextState;
  logic supplyOk;

  assign supplyOk = powerGood & ~powerFail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RECOVER;
    else       state <= nextState;
  end

  always_comb begin
    nextState       = state;
    strobe.cntClear = 1'b0;
    strobe.cntInc   = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (!supplyOk) nextState = ctrlBusy ? ST_DRAIN : ST_RETAIN;
      end
      ST_DRAIN: begin
        if (!ctrlBusy) nextState = ST_RETAIN;
      end
      ST_RETAIN: begin
        if (supplyOk) begin
          nextState       = ST_RECOVER;
          strobe.cntClear = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (!supplyOk)     nextState = ST_RETAIN;
        else if (holdDone) nextState = ST_RUN;
        else               strobe.cntInc = 1'b1;
      end
      default: nextState = ST_RECOVER;
    endcase
  end

  assign memReady   = (state == ST_RUN);
  assign ceDeselect = (state == ST_RETAIN) || (state == ST_RECOVER);

  // R2, R6: access reopens only after a completed hold
  assert_ready_after_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReady) |-> ($past(state) == ST_RECOVER) && $past(holdDone));
  // R3: idle controller means immediate deselect on failure
  assert_fail_deselect_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReady && !supplyOk && !ctrlBusy) |=> ceDeselect && !memReady);
  // R4: a busy controller keeps the enable untouched
  assert_drain_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!memReady && !ceDeselect && ctrlBusy) |=> !ceDeselect && !memReady);
  // R9: leaving drain always deselects
  assert_drain_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!memReady && !ceDeselect && !ctrlBusy) |=> ceDeselect);
  // R5: retention persists while the supply is unhealthy
  assert_retain_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ceDeselect && !supplyOk) |=> ceDeselect && !memReady);
endmodule

// File: rtl/sram_retention_seq.sv
module sram_retention_seq
  import sram_retention_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned HOLD_US = 5000
) (
  input  logic clk,
  input  logic rstN,
  input  logic powerFail,
  input  logic powerGood,
  input  logic ctrlBusy,
  output logic ceDeselect,
  output logic memReady
);
  localparam int unsigned HOLD_CYCLES = (CLK_KHZ * HOLD_US) / 1000;

  holdStrobe_t strobe;
  logic holdDone;

  sram_retention_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .powerFail(powerFail), .powerGood(powerGood),
    .ctrlBusy(ctrlBusy), .holdDone(holdDone), .strobe(strobe),
    .ceDeselect(ceDeselect), .memReady(memReady)
  );

  sram_retention_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rstN(rstN), .strobe(strobe), .holdDone(holdDone)
  );

  // R1: outputs are mutually exclusive
  assert_outputs_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(memReady && ceDeselect));
endmodule

// File: tb/sim_sram_retention_seq.sv
module sim_sram_retention_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_KHZ = 1000;
  localparam int HOLD_US = 20;
  localparam int N = CLK_KHZ * HOLD_US / 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerFail = 1'b0, powerGood = 1'b1, ctrlBusy = 1'b0;
  logic ceDeselect, memReady;

  int checks = 0, errors = 0;
  bit finished = 0;
  int mState = 3;
  int mCnt = 0;

  sram_retention_seq #(.CLK_KHZ(CLK_KHZ), .HOLD_US(HOLD_US)) u0 (
    .clk(clk), .rstN(rstN), .powerFail(powerFail), .powerGood(powerGood),
    .ctrlBusy(ctrlBusy), .ceDeselect(ceDeselect), .memReady(memReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit expReady(int s);
    return s == 0;
  endfunction
  function automatic bit expDesel(int s);
    return s >= 2;
  endfunction

  task automatic check(string tag, bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, memReady, expReady(mState), "memReady");
    check(tag, ceDeselect, expDesel(mState), "ceDeselect");
  endtask

  task automatic step(bit pf, bit pg, bit busy, string tag);
    bit ok;
    powerFail = pf; powerGood = pg; ctrlBusy = busy;
    @(posedge clk);
    ok = pg && !pf;
    case (mState)
      0: if (!ok) mState = busy ? 1 : 2;
      1: if (!busy) mState = 2;
      2: if (ok) begin mState = 3; mCnt = 0; end
      default: begin
        if (!ok) mState = 2;
        else if (mCnt == N-1) mState = 0;
        else mCnt++;
      end
    endcase
    @(negedge clk);
    compare(tag);
  endtask

  task automatic hold(int cycles, string tag);
    for (int i = 0; i < cycles; i++) step(1'b0, 1'b1, 1'b0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit pf, pg, bz;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", memReady, 1'b0, "memReady in reset");
    check("R1", ceDeselect, 1'b1, "ceDeselect in reset");
    rstN = 1'b1;
    mState = 3; mCnt = 0;
    compare("R1");
    // R2: power-up hold
    hold(N-1, "R2");
    check("R2", memReady, 1'b0, "memReady before hold end");
    step(1'b0, 1'b1, 1'b0, "R2");
    check("R2", memReady, 1'b1, "memReady at hold end");
    // R3: idle failure
    step(1'b1, 1'b0, 1'b0, "R3");
    check("R3", ceDeselect, 1'b1, "ceDeselect after fail");
    // R5: stays in retention
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, "R5");
    // R6: full recovery hold
    hold(N, "R6");
    check("R6", memReady, 1'b0, "memReady one edge before hold end");
    step(1'b0, 1'b1, 1'b0, "R6");
    check("R6", memReady, 1'b1, "memReady after hold");
    // R4: busy drain
    step(1'b1, 1'b1, 1'b1, "R4");
    check("R4", ceDeselect, 1'b0, "ceDeselect while draining");
    step(1'b0, 1'b1, 1'b1, "R4");
    step(1'b0, 1'b1, 1'b1, "R4");
    check("R4", memReady, 1'b0, "memReady while draining");
    // R9: drain exit with healthy supply still deselects
    step(1'b0, 1'b1, 1'b0, "R9");
    check("R9", ceDeselect, 1'b1, "ceDeselect at drain exit");
    hold(N, "R9");
    check("R9", memReady, 1'b0, "memReady before full hold");
    step(1'b0, 1'b1, 1'b0, "R9");
    // R7: failure mid-hold restarts
    step(1'b0, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, "R7");
    hold(N/2, "R7");
    step(1'b1, 1'b1, 1'b0, "R7");
    check("R7", ceDeselect, 1'b1, "ceDeselect after mid-hold fail");
    hold(N, "R7");
    check("R7", memReady, 1'b0, "memReady with restarted hold");
    step(1'b0, 1'b1, 1'b0, "R7");
    check("R7", memReady, 1'b1, "memReady after restarted hold");
    // R8: power-good low alone
    step(1'b0, 1'b0, 1'b0, "R8");
    check("R8", memReady, 1'b0, "memReady with powerGood low");
    hold(N + 1, "R8");
    // Random mix against the model
    for (int i = 0; i < 3000; i++) begin
      pf = ($urandom_range(0, 15) == 0);
      pg = ($urandom_range(0, 15) != 0);
      bz = ($urandom_range(0, 2) == 0);
      step(pf, pg, bz, "R5");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule